// File: doc/BRIEF.md
# Memory Access Watch Interrupt Unit

This block monitors traffic into three memory regions: a general on-chip RAM (region 0), a data tightly-coupled memory (region 1) and an instruction tightly-coupled memory (region 2). Each region can raise two kinds of event. The first is an access to an unallocated address. The address decoder outside this block detects that case and signals it on a one-cycle pulse input. The second is an access that falls on a programmable watch address. The watch address is compared at 8-byte granularity, and only accesses of one selected direction count.

Events set sticky flags in a six-bit status register. A status-enable mask decides which events may set a flag. A separate signal-enable mask decides which set flags drive the single interrupt output. Software reaches status, both masks and the three watch registers over a small synchronous register bus. Writes take effect on the clock edge. Reads are combinational on the selected address. Status flags are cleared by writing ones.

Register addresses: 0 status, 1 status-enable, 2 signal-enable, 3/4/5 watch register of region 0/1/2. All other addresses read zero and ignore writes.

Top module: `mem_watch_irq`

## Requirements
- R1: Asynchronous active-low reset clears the status register, both enable masks, all three watch registers and the interrupt output, so every register address reads zero.
- R2: Status bit r (r = 0..2) is set on the clock edge at which the region-r unallocated-access pulse is high, provided status-enable bit r is 1. It then stays set until cleared.
- R3: An event whose status-enable bit is 0 leaves its status flag unchanged.
- R4: Status bit 3+r is set when region r has a valid access whose byte address, shifted right by 3, equals the stored unit address of the region-r watch register, with the direction matching and status-enable bit 3+r set. An access in any other 8-byte unit does not set it.
- R5: The watch direction bit is 0 to match reads and 1 to match writes. An access of the other direction never sets the match flag.
- R6: Writing to the status address clears every status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R7: If an enabled event and a write-one-to-clear hit the same status bit on the same edge, the bit ends up set.
- R8: The interrupt output equals the OR over all bits of (status AND signal-enable), registered once. It therefore follows a status change one clock edge later.
- R9: Status and both enable masks hold six bits, and data bits 6 and above read as zero. A write to status can only clear bits, never set them.
- R10: A watch register holds the direction in data bit 0 and the unit address (ADDR_W-3 bits) in the bits directly above it. All higher bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on reg_addr |
| acc_valid | input | 3 | Per-region access valid |
| acc_write | input | 3 | Per-region access direction, 1 = write |
| acc_addr | input | 3*ADDR_W | Per-region byte address, region r in bits [r*ADDR_W +: ADDR_W] |
| unalloc_err | input | 3 | Per-region unallocated-access pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with ADDR_W = 8 and DATA_W = 16. With those values the full 256-byte address space of every region can be swept for both watch directions and both access directions, which covers each unit boundary and every direction pairing. The six-bit masks make it possible to try all 64 status-enable patterns against each event and all 64 signal-enable patterns against each status bit. Directed cases cover the coincident set and clear, readback truncation and the one-cycle interrupt lag.

// File: rtl/mem_watch_irq.sv
module mem_watch_irq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [2:0]            reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [2:0]            acc_valid,
  input  logic [2:0]            acc_write,
  input  logic [3*ADDR_W-1:0]   acc_addr,
  input  logic [2:0]            unalloc_err,
  output logic                  irq
);
  localparam int NR     = 3;
  localparam int NS     = 2 * NR;
  localparam int UNIT_W = ADDR_W - 3;
  localparam logic [2:0] A_STAT  = 3'd0;
  localparam logic [2:0] A_SEN   = 3'd1;
  localparam logic [2:0] A_GEN   = 3'd2;
  localparam logic [2:0] A_WATCH = 3'd3;

  logic [NS-1:0]          status, stat_en, sig_en;
  logic [NR-1:0]          w_dir;
  logic [UNIT_W-1:0]      w_unit [NR];
  logic [NR-1:0]          hit;
  logic [NS-1:0]          evt, set_v, clr_v;

  for (genvar r = 0; r < NR; r++) begin : g_rgn
    logic [ADDR_W-1:0] a;
    assign a      = acc_addr[r*ADDR_W +: ADDR_W];
    assign hit[r] = acc_valid[r] && (acc_write[r] == w_dir[r]) && (a[ADDR_W-1:3] == w_unit[r]);

    AST_MISDIR_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_valid[r] && (acc_write[r] != w_dir[r])) |-> !$rose(status[NR+r])); // R5
  end

  assign evt   = {hit, unalloc_err};
  assign set_v = evt & stat_en;
  assign clr_v = (reg_we && reg_addr == A_STAT) ? reg_wdata[NS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      stat_en <= '0;
      sig_en  <= '0;
      w_dir   <= '0;
      irq     <= 1'b0;
      for (int r = 0; r < NR; r++) w_unit[r] <= '0;
    end else begin
      status <= (status & ~clr_v) | set_v;
      irq    <= |(status & sig_en);
      if (reg_we && reg_addr == A_SEN) stat_en <= reg_wdata[NS-1:0];
      if (reg_we && reg_addr == A_GEN) sig_en  <= reg_wdata[NS-1:0];
      for (int r = 0; r < NR; r++) begin
        if (reg_we && reg_addr == A_WATCH + 3'(r)) begin
          w_dir[r]  <= reg_wdata[0];
          w_unit[r] <= reg_wdata[UNIT_W:1];
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT:  reg_rdata = DATA_W'(status);
      A_SEN:   reg_rdata = DATA_W'(stat_en);
      A_GEN:   reg_rdata = DATA_W'(sig_en);
      3'd3:    reg_rdata = DATA_W'({w_unit[0], w_dir[0]});
      3'd4:    reg_rdata = DATA_W'({w_unit[1], w_dir[1]});
      3'd5:    reg_rdata = DATA_W'({w_unit[2], w_dir[2]});
      default: reg_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata, acc_addr};

  AST_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & ~$past(evt)) == '0); // R2
  AST_RISE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & ~$past(stat_en)) == '0); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_addr == A_STAT) |->
      ((status & $past(reg_wdata[NS-1:0]) & ~$past(evt & stat_en)) == '0)); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & $past(evt & stat_en)) == $past(evt & stat_en))); // R7
  AST_IRQ_NEEDS_SIGEN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(sig_en) != '0)); // R8
  AST_STATUS_READ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_STAT) |-> (reg_rdata[DATA_W-1:NS] == '0)); // R9
endmodule

// File: tb/mem_watch_irq_tb_top.sv
module mem_watch_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int UNIT_W = ADDR_W - 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [2:0] acc_valid = '0, acc_write = '0, unalloc_err = '0;
  logic [3*ADDR_W-1:0] acc_addr = '0;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_watch_irq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .unalloc_err(unalloc_err), .irq(irq));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = DATA_W'(d);
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    reg_addr = 3'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  function automatic int unit_of(int r);
    return 5 + 7 * r;
  endfunction

  // drive event b for one edge: b<3 unallocated pulse, else watch hit on region b-3 (dir 0 = read)
  task automatic drive_event(int b);
    if (b < 3) unalloc_err[b] = 1'b1;
    else begin
      acc_valid[b-3] = 1'b1;
      acc_write[b-3] = 1'b0;
      acc_addr[(b-3)*ADDR_W +: ADDR_W] = ADDR_W'((unit_of(b-3) << 3) | 3);
    end
  endtask

  task automatic idle_inputs();
    unalloc_err = '0; acc_valid = '0; acc_write = '0; acc_addr = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(a, d); chk("R1 reset register", d, 0);
    end
    chk("R1 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    tick();

    // R10 / R9 readback truncation
    wr(3, 16'hFFFF); rd(3, d); chk("R10 watch layout", d, (1 << (UNIT_W + 1)) - 1);
    wr(4, (9 << 1) | 1); rd(4, d); chk("R10 watch fields", d, 19);
    wr(1, 16'hFFFF); rd(1, d); chk("R9 status-enable width", d, 16'h3F);
    wr(2, 16'hFFC0); rd(2, d); chk("R9 signal-enable width", d, 0);
    wr(0, 16'hFFFF); rd(0, d); chk("R9 status write cannot set", d, 0);
    rd(6, d); chk("R9 unused address", d, 0);

    // R4 / R5 sweep over every address, both watch and access directions
    wr(1, 16'h3F); wr(2, 0);
    for (int r = 0; r < 3; r++) begin
      for (int sel = 0; sel < 2; sel++) begin
        wr(3 + r, (unit_of(r) << 1) | sel);
        for (int dir = 0; dir < 2; dir++) begin
          for (int ad = 0; ad < 256; ad++) begin
            int exp;
            acc_valid[r] = 1'b1; acc_write[r] = dir[0];
            acc_addr[r*ADDR_W +: ADDR_W] = ADDR_W'(ad);
            tick();
            idle_inputs();
            exp = (dir == sel && (ad >> 3) == unit_of(r)) ? (1 << (3 + r)) : 0;
            rd(0, d);
            chk(dir == sel ? "R4 watch unit match" : "R5 direction filter", d, exp);
            if (d != 0) wr(0, 16'h3F);
          end
        end
      end
      wr(3 + r, unit_of(r) << 1);
    end

    // R2 / R3 every status-enable pattern against every event
    for (int en = 0; en < 64; en++) begin
      wr(1, en);
      for (int b = 0; b < 6; b++) begin
        drive_event(b);
        tick();
        idle_inputs();
        rd(0, d);
        chk(b < 3 ? "R2 error flag under enable R3" : "R3 match flag gating", d, (1 << b) & en);
        wr(0, 16'h3F);
      end
    end

    // R2 sticky, R6 selective clear
    wr(1, 16'h3F);
    for (int b = 0; b < 6; b++) begin drive_event(b); tick(); end
    idle_inputs();
    tick();
    rd(0, d); chk("R2 flags stay set", d, 16'h3F);
    wr(0, 16'h15); rd(0, d); chk("R6 clear ones only", d, 16'h2A);
    wr(0, 16'h00); rd(0, d); chk("R6 zero write keeps", d, 16'h2A);
    wr(0, 16'h3F); rd(0, d); chk("R6 clear all", d, 0);

    // R7 set wins over simultaneous clear
    drive_event(1); tick(); idle_inputs();
    unalloc_err[0] = 1'b1;
    wr(0, 16'h03);
    idle_inputs();
    rd(0, d); chk("R7 set beats clear", d, 16'h01);
    wr(0, 16'h3F);

    // R8 every signal-enable pattern against every status bit, with lag
    for (int sg = 0; sg < 64; sg++) begin
      wr(2, sg);
      for (int b = 0; b < 6; b++) begin
        drive_event(b);
        tick();
        idle_inputs();
        chk("R8 irq lags status", int'(irq), 0);
        tick();
        chk("R8 irq mask", int'(irq), (sg >> b) & 1);
        wr(0, 16'h3F);
        tick();
        chk("R8 irq drops after clear", int'(irq), 0);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule